// File: doc/BRIEF.md
# Migrating Non-Uniform-Latency Cache Bank-Set Controller

This block manages one group of cache sets whose ways are spread over several physical banks, each bank sitting at a different wire distance from the requester and so answering after a different number of cycles. An incoming address is split into a set index and a tag. The tag is compared in every bank of the chosen set in the same cycle. The response then returns after the latency of the bank that held the line. A miss returns after the latency of the furthest bank plus the memory refill.

Placement is handled by moving lines between banks instead of by recency bits. A line that hits moves one bank nearer by trading places with its neighbour. A missing line always enters at the furthest bank, and the line it displaces leaves the set entirely. A dirty displaced line is sent out on a writeback port in the cycle that the refill is requested. The request port takes one transaction at a time and stays closed until that transaction, including any migration, has finished.

Top module: `nuca_bankset`

## Requirements
- R1: The request address is `{tag, index}`, with the index in the low `$clog2(SETS)` bits. Lines with equal tags in different sets are independent.
- R2: A lookup compares the tag in all banks of the set at once. At most one bank ever reports a match, because a line is held in one bank only.
- R3: A hit's `rsp_valid` rises exactly `L[b]` cycles after the accepting clock edge, where b is the bank that matched (bank 0 nearest). The defaults are L = 4, 10, 20 and 47.
- R4: After a hit in bank b > 0, the line and the line in bank b-1 trade places in the cycle after the response. A hit in bank 0 moves nothing. `rsp_bank` reports the bank where the line was found.
- R5: A miss returns `rsp_hit`=0 with `rsp_bank` = NB-1, after the refill has arrived.
- R6: The refilled line is always written into bank NB-1 of the set, never into a nearer bank.
- R7: If the line in bank NB-1 is valid and dirty when a miss is handled, `wb_valid` pulses once with that line's address and data, in the same cycle as `fill_req_valid`. A clean or empty victim produces no writeback.
- R8: The displaced line is dropped from the set. A later request for it misses and is fetched again from memory.
- R9: `req_ready` is low from the cycle after acceptance until the response has been given and any swap has been done.
- R10: A write hit replaces the line's data and marks it dirty. A write miss installs the write data as a dirty line. For a write, `rsp_data` returns the written data; for a read, it returns the stored data.
- R11: After reset all lines are invalid, `req_ready` is 1 and `rsp_valid`, `fill_req_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAG_W+log2(SETS) | `{tag, index}` |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_bank | output | log2(NB) | Bank that supplied the line |
| rsp_data | output | DATA_W | Line data |
| fill_req_valid | output | 1 | Refill request strobe |
| fill_req_addr | output | TAG_W+log2(SETS) | Address to refill |
| fill_valid | input | 1 | Refill data present |
| fill_data | input | DATA_W | Refill data |
| wb_valid | output | 1 | Writeback strobe for a dirty victim |
| wb_addr | output | TAG_W+log2(SETS) | Victim address |
| wb_data | output | DATA_W | Victim data |

## Verification
Eviction of a dirty victim and the refill request for the incoming line share one cycle. The bench provokes this with a write miss, which leaves a dirty line in the furthest bank, followed by a read miss to the same set. The writeback monitor requires `fill_req_valid` to be high whenever `wb_valid` is, and checks the victim's address and data against the reference model. The bench memory only takes the written-back data from the writeback port, so a later refill of that address shows whether the writeback carried the right data.

// File: rtl/nuca_pkg.sv
package nuca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EVICT,
    ST_FILL,
    ST_RESP,
    ST_SWAP
  } nuca_state_e;
endpackage

// File: rtl/nuca_bank.sv
module nuca_bank #(
  parameter int unsigned SETS   = 8,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cmp_set,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              cmp_hit,
  input  logic [IDX_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= wr_valid;
      dirty_q[wr_set] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign cmp_hit  = valid_q[cmp_set] && (tag_q[cmp_set] == cmp_tag);
  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];
endmodule

// File: rtl/nuca_delay.sv
module nuca_delay #(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             expire
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == LAT_W'(1));

  // R3: a bank latency of zero would never expire
  a_r3_nonzero_lat: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
  // R3: the controller never restarts a running countdown
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
endmodule

// File: rtl/nuca_bankset.sv
module nuca_bankset
  import nuca_pkg::*;
#(
  parameter int unsigned SETS   = 8,
  parameter int unsigned NB     = 4,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT_W  = 8,
  parameter logic [NB*LAT_W-1:0] BANK_LAT = {8'd47, 8'd20, 8'd10, 8'd4}
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_write,
  input  logic [TAG_W+$clog2(SETS)-1:0]      req_addr,
  input  logic [DATA_W-1:0]                  req_wdata,
  output logic                               rsp_valid,
  output logic                               rsp_hit,
  output logic [$clog2(NB)-1:0]              rsp_bank,
  output logic [DATA_W-1:0]                  rsp_data,
  output logic                               fill_req_valid,
  output logic [TAG_W+$clog2(SETS)-1:0]      fill_req_addr,
  input  logic                               fill_valid,
  input  logic [DATA_W-1:0]                  fill_data,
  output logic                               wb_valid,
  output logic [TAG_W+$clog2(SETS)-1:0]      wb_addr,
  output logic [DATA_W-1:0]                  wb_data
);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned ADDR_W = TAG_W + IDX_W;
  localparam int unsigned BANK_W = $clog2(NB);
  localparam int unsigned LAST   = NB - 1;

  function automatic logic [LAT_W-1:0] lat_of(input logic [BANK_W-1:0] b);
    return BANK_LAT[int'(b)*LAT_W +: LAT_W];
  endfunction

  function automatic logic [BANK_W-1:0] idx_of(input logic [NB-1:0] v);
    logic [BANK_W-1:0] r;
    r = '0;
    for (int i = 0; i < NB; i++)
      if (v[i]) r = BANK_W'(i);
    return r;
  endfunction

  nuca_state_e st;
  logic [IDX_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_hit;
  logic [BANK_W-1:0] cur_bank;
  logic [LAT_W-1:0]  elapsed;

  logic [NB-1:0]             look_hit;
  logic [NB-1:0]             rd_valid;
  logic [NB-1:0]             rd_dirty;
  logic [NB-1:0][TAG_W-1:0]  rd_tag;
  logic [NB-1:0][DATA_W-1:0] rd_data;

  logic [IDX_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic              accept;
  logic              look_any;
  logic [BANK_W-1:0] look_bank;
  logic [LAT_W-1:0]  look_lat;
  logic              expire;

  // named internal events
  logic wr_hit;
  logic wr_fill;
  logic swap_en;

  assign req_set   = req_addr[IDX_W-1:0];
  assign req_tag   = req_addr[ADDR_W-1:IDX_W];
  assign accept    = req_valid && (st == ST_IDLE);
  assign look_any  = |look_hit;
  assign look_bank = idx_of(look_hit);
  assign look_lat  = look_any ? lat_of(look_bank) : lat_of(BANK_W'(LAST));

  assign wr_hit  = (st == ST_RESP) && cur_hit && cur_write;
  assign wr_fill = (st == ST_FILL) && fill_valid;
  assign swap_en = (st == ST_SWAP);

  nuca_delay #(.LAT_W(LAT_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (look_lat),
    .expire   (expire)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam bit HAS_DN = (b > 0);
    localparam bit HAS_UP = (b < LAST);
    localparam int unsigned DN = HAS_DN ? b - 1 : 0;
    localparam int unsigned UP = HAS_UP ? b + 1 : LAST;

    logic              we;
    logic              wv;
    logic              wd;
    logic [TAG_W-1:0]  wt;
    logic [DATA_W-1:0] wdat;

    always_comb begin
      we   = 1'b0;
      wv   = 1'b0;
      wd   = 1'b0;
      wt   = cur_tag;
      wdat = cur_wdata;
      if (wr_hit && (cur_bank == BANK_W'(b))) begin
        we = 1'b1; wv = 1'b1; wd = 1'b1;
      end
      if ((b == LAST) && wr_fill) begin
        we = 1'b1; wv = 1'b1; wd = cur_write;
        wdat = cur_write ? cur_wdata : fill_data;
      end
      // swap: the promoted line arrives from the bank behind
      if (HAS_UP && swap_en && (cur_bank == BANK_W'(UP))) begin
        we = 1'b1; wv = rd_valid[UP]; wd = rd_dirty[UP];
        wt = rd_tag[UP]; wdat = rd_data[UP];
      end
      // swap: the demoted line arrives from the bank in front
      if (HAS_DN && swap_en && (cur_bank == BANK_W'(b))) begin
        we = 1'b1; wv = rd_valid[DN]; wd = rd_dirty[DN];
        wt = rd_tag[DN]; wdat = rd_data[DN];
      end
    end

    nuca_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_set  (req_set),
      .cmp_tag  (req_tag),
      .cmp_hit  (look_hit[b]),
      .rd_set   (cur_set),
      .rd_valid (rd_valid[b]),
      .rd_dirty (rd_dirty[b]),
      .rd_tag   (rd_tag[b]),
      .rd_data  (rd_data[b]),
      .wr_en    (we),
      .wr_set   (cur_set),
      .wr_valid (wv),
      .wr_dirty (wd),
      .wr_tag   (wt),
      .wr_data  (wdat)
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_set   <= '0;
      cur_tag   <= '0;
      cur_write <= 1'b0;
      cur_wdata <= '0;
      cur_hit   <= 1'b0;
      cur_bank  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st        <= ST_WAIT;
          cur_set   <= req_set;
          cur_tag   <= req_tag;
          cur_write <= req_write;
          cur_wdata <= req_wdata;
          cur_hit   <= look_any;
          cur_bank  <= look_bank;
        end
        ST_WAIT:  if (expire) st <= cur_hit ? ST_RESP : ST_EVICT;
        ST_EVICT: st <= ST_FILL;
        ST_FILL:  if (fill_valid) st <= ST_RESP;
        ST_RESP:  st <= (cur_hit && (cur_bank != '0)) ? ST_SWAP : ST_IDLE;
        ST_SWAP:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                elapsed <= '0;
    else if (accept)           elapsed <= '0;
    else if (elapsed != '1)    elapsed <= elapsed + 1'b1;
  end

  assign req_ready      = (st == ST_IDLE);
  assign rsp_valid      = (st == ST_RESP);
  assign rsp_hit        = cur_hit;
  assign rsp_bank       = cur_hit ? cur_bank : BANK_W'(LAST);
  assign rsp_data       = cur_write ? cur_wdata : rd_data[rsp_bank];
  assign fill_req_valid = (st == ST_EVICT);
  assign fill_req_addr  = {cur_tag, cur_set};
  assign wb_valid       = (st == ST_EVICT) && rd_valid[LAST] && rd_dirty[LAST];
  assign wb_addr        = {rd_tag[LAST], cur_set};
  assign wb_data        = rd_data[LAST];

  // R2: the parallel tag compare never finds two copies
  a_r2_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit));
  // R3: hit answered after exactly the matching bank's latency
  a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (elapsed == lat_of(rsp_bank)));
  // R4: a hit outside the nearest bank is followed by a swap
  a_r4_swap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && (rsp_bank != '0)) |=> swap_en);
  // R4: after the swap the nearer bank holds the promoted line
  a_r4_line_moved: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |=> (rd_tag[$past(cur_bank) - 1'b1] == $past(rd_tag[cur_bank])));
  // R6: refill lands in the furthest bank
  a_r6_fill_far: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fill |=> (rd_valid[LAST] && (rd_tag[LAST] == $past(cur_tag))));
  // R9: port closed after acceptance
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/nuca_bankset_test.sv
module nuca_bankset_test;
  localparam int NB = 4;
  localparam int SETS = 8;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int MEMN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic req_ready, rsp_valid, rsp_hit, fill_req_valid, wb_valid;
  logic [1:0] rsp_bank;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] fill_req_addr, wb_addr;

  always #5 clk = ~clk;

  nuca_bankset uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bank(rsp_bank), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int lat_tab [NB] = '{4, 10, 20, 47};

  typedef struct { bit hit; int bank; logic [DW-1:0] data; int lat; int t0; } exp_t;
  typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; } wbx_t;
  exp_t exp_q[$];
  wbx_t wb_q[$];

  // reference model
  bit            m_valid [SETS][NB];
  bit            m_dirty [SETS][NB];
  logic [7:0]    m_tag   [SETS][NB];
  logic [DW-1:0] m_data  [SETS][NB];
  logic [DW-1:0] mem_ref  [MEMN];
  logic [DW-1:0] mem_real [MEMN];

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] tag, input int set, input bit wr, input logic [DW-1:0] wd);
    exp_t e;
    int hb = -1;
    logic [AW-1:0] a;
    a = {tag, 3'(set)};
    for (int b = 0; b < NB; b++)
      if (m_valid[set][b] && m_tag[set][b] == tag) hb = b;
    if (hb >= 0) begin
      e.hit = 1; e.bank = hb; e.lat = lat_tab[hb];
      if (wr) begin m_data[set][hb] = wd; m_dirty[set][hb] = 1; end
      e.data = m_data[set][hb];
      if (hb > 0) begin
        bit v; bit d; logic [7:0] t; logic [DW-1:0] x;
        v = m_valid[set][hb-1]; d = m_dirty[set][hb-1]; t = m_tag[set][hb-1]; x = m_data[set][hb-1];
        m_valid[set][hb-1] = m_valid[set][hb]; m_dirty[set][hb-1] = m_dirty[set][hb];
        m_tag[set][hb-1] = m_tag[set][hb]; m_data[set][hb-1] = m_data[set][hb];
        m_valid[set][hb] = v; m_dirty[set][hb] = d; m_tag[set][hb] = t; m_data[set][hb] = x;
      end
    end else begin
      wbx_t w;
      if (m_valid[set][NB-1] && m_dirty[set][NB-1]) begin
        w.addr = {m_tag[set][NB-1], 3'(set)};
        w.data = m_data[set][NB-1];
        wb_q.push_back(w);
        mem_ref[w.addr] = w.data;
      end
      e.hit = 0; e.bank = NB-1; e.lat = 0;
      e.data = wr ? wd : mem_ref[a];
      m_valid[set][NB-1] = 1; m_dirty[set][NB-1] = wr;
      m_tag[set][NB-1] = tag; m_data[set][NB-1] = e.data;
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    e.t0 = cyc;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R9", "ready after accept", req_ready, 0);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // response monitor (scoreboard)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R5", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.hit ? "R2" : "R5", "hit flag", rsp_hit, e.hit);
        chk("R4", "bank", rsp_bank, e.bank);
        chk("R10", "data", rsp_data, e.data);
        if (e.hit) chk("R3", "latency", cyc - e.t0 - 1, e.lat);
      end
    end
  end

  // writeback monitor, R7
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      chk("R7", "refill request with writeback", fill_req_valid, 1);
      if (wb_q.size() == 0) chk("R7", "unexpected writeback", 1, 0);
      else begin
        wbx_t w;
        w = wb_q.pop_front();
        chk("R7", "wb addr", wb_addr, w.addr);
        chk("R7", "wb data", wb_data, w.data);
      end
      mem_real[wb_addr] = wb_data;
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fill_req_valid) begin
        logic [AW-1:0] fa;
        fa = fill_req_addr;
        repeat (3) @(negedge clk);
        fill_valid = 1; fill_data = mem_real[fa];
        @(negedge clk);
        fill_valid = 0;
      end
    end
  end

  task automatic finish_run();
    chk("R7", "pending writebacks", wb_q.size(), 0);
    chk("R5", "pending responses", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      mem_ref[i] = 16'(i * 37 + 16'h1234);
      mem_real[i] = mem_ref[i];
    end
    for (int s = 0; s < SETS; s++)
      for (int b = 0; b < NB; b++) begin
        m_valid[s][b] = 0; m_dirty[s][b] = 0; m_tag[s][b] = '0; m_data[s][b] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "ready", req_ready, 1);
    chk("R11", "rsp_valid", rsp_valid, 0);
    chk("R11", "wb_valid", wb_valid, 0);
    chk("R11", "fill_req_valid", fill_req_valid, 0);

    // R5/R6: miss installs in furthest bank, then R4 promotion step by step
    do_req(8'h11, 0, 0, '0);
    do_req(8'h11, 0, 0, '0);   // hit bank 3, latency 47
    do_req(8'h11, 0, 0, '0);   // hit bank 2
    do_req(8'h11, 0, 0, '0);   // hit bank 1
    do_req(8'h11, 0, 0, '0);   // hit bank 0, no move
    do_req(8'h11, 0, 0, '0);   // still bank 0
    // R10: write miss makes a dirty line in bank 3
    do_req(8'h22, 0, 1, 16'hBEEF);
    // R7: read miss evicts the dirty line; writeback with fill request
    do_req(8'h33, 0, 0, '0);
    // R8: evicted line misses again and returns written-back data
    do_req(8'h22, 0, 0, '0);
    do_req(8'h33, 0, 0, '0);
    // R10: write hit in bank 3 then promotion
    do_req(8'h33, 0, 1, 16'h7777);
    do_req(8'h33, 0, 0, '0);
    // R1: same tag in another set is independent
    do_req(8'h11, 3, 0, '0);
    do_req(8'h11, 0, 0, '0);
    do_req(8'h11, 3, 0, '0);

    // mixed traffic over two sets
    for (int n = 0; n < 220; n++) begin
      logic [7:0] t;
      int s;
      bit w;
      t = 8'h40 + 8'($urandom_range(0, 5));
      s = 1 + int'($urandom_range(0, 1));
      w = ($urandom_range(0, 2) == 0);
      do_req(t, s, w, 16'($urandom));
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule